// File: doc/BRIEF.md
# DDR SDRAM Initialization and Refresh Sequencer

This block sits on the controller side of a DDR SDRAM interface. After reset it takes the memory from power-up to the operational state. It holds the clock enable high and drives no-operation commands for a startup delay. It then precharges all banks and writes the extended mode register to turn the DLL on. Next it writes the mode register with the DLL reset bit set, precharges again, and issues two auto-refreshes. Last, it rewrites the mode register without the DLL reset bit. It reports ready only once the DLL lock count has elapsed since the DLL reset, so that no read can be issued too early.

Once ready, a free-running interval timer adds one refresh to a small pending counter every average refresh interval. The block requests refresh from an external arbiter while refreshes are pending, and it raises an urgent flag when the counter is full. When the arbiter grants, the block drives an auto-refresh command and keeps the row cycle time before the next one. All timing parameters are given in nanoseconds and converted to clock counts from the clock-period parameter, rounding up.

Top module: `ddr_init_refresh`

## Requirements
- R1: While reset is asserted, CKE is low, chip select is high, and initDone, refReq and refUrgent are low. From the first cycle after reset, CKE is high and, until the first command, only NOP (chip select low, RAS/CAS/WE high) is driven.
- R2: The first command other than NOP is a precharge-all (RAS low, CAS high, WE low, A10 high). It appears no earlier than STARTUP_NS worth of clocks after reset release, and at most two cycles later than that.
- R3: The initialization commands come in exactly this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, auto-refresh (RAS low, CAS low, WE high), auto-refresh, mode write without DLL reset.
- R4: The extended mode write has CS, RAS, CAS and WE low, BA = 01 and all address bits zero. A0 = 0 enables the DLL.
- R5: A mode write has CS, RAS, CAS and WE low and BA = 00. Its address bits are: A[2:0] = burstLen code, A3 = burstInterleave, A[6:4] = casLat code (010 = 2, 011 = 3, 110 = 2.5), A7 = 0, A8 = DLL reset, and A[11:9] = 0.
- R6: Spacing between consecutive commands is tRP after a precharge, tMRD (2 clocks) after a mode write, and tRFC after an auto-refresh. Each value in clocks is ceil(ns*1000/TCK_PS).
- R7: initDone rises no earlier than LOCK_CLKS cycles after the mode write with DLL reset appears on the pins, and at most three cycles later.
- R8: refReq rises exactly TREFI cycles after initDone rises, where TREFI is TREFI_NS in clocks.
- R9: Without refGrant, no command other than NOP is driven after initialization. When refGrant is seen with refReq high and tRFC has elapsed, an auto-refresh appears on the pins in the next cycle, and each grant consumes one pending refresh.
- R10: The pending count saturates at MAX_PEND. After more intervals than MAX_PEND have elapsed with no grant, a continuous grant yields exactly MAX_PEND auto-refreshes, spaced tRFC apart, and then refReq drops.
- R11: refUrgent rises exactly MAX_PEND*TREFI cycles after initDone when no grant is given. It falls as soon as a pending refresh is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstLen | input | 3 | Burst length code placed in A[2:0] of mode writes |
| burstInterleave | input | 1 | Burst type bit placed in A3 (1 = interleaved) |
| casLat | input | 3 | CAS latency code placed in A[6:4] |
| refGrant | input | 1 | Arbiter permission to issue an auto-refresh |
| ddrCke | output | 1 | Clock enable to the memory |
| ddrCsN | output | 1 | Chip select, active low |
| ddrRasN | output | 1 | Row strobe, active low |
| ddrCasN | output | 1 | Column strobe, active low |
| ddrWeN | output | 1 | Write enable, active low |
| ddrBa | output | 2 | Bank address |
| ddrAddr | output | ADDR_W | Address bus |
| initDone | output | 1 | Initialization complete and DLL lock time met |
| refReq | output | 1 | At least one refresh pending |
| refUrgent | output | 1 | Pending refresh count is full |

## Verification
The bench records every command on the pins together with its cycle, and compares the initialization trace entry by entry against an expected table of opcode, address, bank and gap. This catches a swapped order, a missing DLL reset bit, a misplaced CAS latency field, or an off-by-one in a tRP, tMRD or tRFC countdown. It measures the ready edge against the DLL-reset command, so a design that reports ready after the last mode write alone fails. The bench also times the first request and the urgent flag to the exact cycle. It then holds grant off for several extra intervals and counts the refreshes served: a counter that wraps instead of saturating yields too few, and one that ignores the grant or the tRFC spacing shows up as an unexpected or crowded command.

// File: rtl/ddrseq_pkg.sv
package ddrseq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PALL,
    CMD_REF,
    CMD_MRS,
    CMD_EMRS
  } cmd_e;

  typedef enum logic [1:0] {
    GAP_RP,
    GAP_MRD,
    GAP_RFC
  } gap_e;

  typedef struct packed {
    logic issue;
    cmd_e cmd;
    logic dllRst;
    gap_e gap;
    logic refRun;
  } seq_strobe_t;

  function automatic int ns2cyc(input int ns, input int tckPs);
    int c;
    c = (ns * 1000 + tckPs - 1) / tckPs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ddrseq_datapath.sv
module ddrseq_datapath
  import ddrseq_pkg::*;
#(
  parameter int TCK_PS     = 5000,
  parameter int STARTUP_NS = 200000,
  parameter int TRP_NS     = 15,
  parameter int TRFC_NS    = 70,
  parameter int TMRD_CLKS  = 2,
  parameter int TREFI_NS   = 15600,
  parameter int LOCK_CLKS  = 200,
  parameter int MAX_PEND   = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       stb,
  input  logic [2:0]        burstLen,
  input  logic              burstInterleave,
  input  logic [2:0]        casLat,
  output logic              gapDone,
  output logic              lockDone,
  output logic              pendNz,
  output logic              pendFull,
  output logic              ddrCke,
  output logic              ddrCsN,
  output logic              ddrRasN,
  output logic              ddrCasN,
  output logic              ddrWeN,
  output logic [1:0]        ddrBa,
  output logic [ADDR_W-1:0] ddrAddr
);

  localparam int STARTUP_CYC = ns2cyc(STARTUP_NS, TCK_PS);
  localparam int RP_CYC      = ns2cyc(TRP_NS, TCK_PS);
  localparam int RFC_CYC     = ns2cyc(TRFC_NS, TCK_PS);
  localparam int MRD_CYC     = (TMRD_CLKS < 1) ? 1 : TMRD_CLKS;
  localparam int REFI_CYC    = ns2cyc(TREFI_NS, TCK_PS);
  localparam int MAXGAP_A    = (RP_CYC > RFC_CYC) ? RP_CYC : RFC_CYC;
  localparam int MAXGAP_B    = (MAXGAP_A > MRD_CYC) ? MAXGAP_A : MRD_CYC;
  localparam int MAXGAP      = (MAXGAP_B > STARTUP_CYC) ? MAXGAP_B : STARTUP_CYC;
  localparam int GAP_W       = $clog2(MAXGAP + 1);
  localparam int LOCK_W      = $clog2(LOCK_CLKS + 1);
  localparam int REFI_W      = $clog2(REFI_CYC + 1);
  localparam int PEND_W      = $clog2(MAX_PEND + 1);

  // command spacing countdown
  logic [GAP_W-1:0] gapCnt;
  logic [GAP_W-1:0] gapLoad;

  always_comb begin
    case (stb.gap)
      GAP_RP:  gapLoad = GAP_W'(RP_CYC - 1);
      GAP_RFC: gapLoad = GAP_W'(RFC_CYC - 1);
      default: gapLoad = GAP_W'(MRD_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              gapCnt <= GAP_W'(STARTUP_CYC);
    else if (stb.issue)     gapCnt <= gapLoad;
    else if (gapCnt != '0)  gapCnt <= gapCnt - 1'b1;
  end

  assign gapDone = (gapCnt == '0);

  // DLL lock counter, restarted by the DLL reset mode write
  logic [LOCK_W-1:0] lockCnt;
  logic              dllRstIssue;
  assign dllRstIssue = stb.issue && (stb.cmd == CMD_MRS) && stb.dllRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  lockCnt <= '0;
    else if (dllRstIssue)                       lockCnt <= '0;
    else if (lockCnt != LOCK_W'(LOCK_CLKS))     lockCnt <= lockCnt + 1'b1;
  end

  assign lockDone = (lockCnt == LOCK_W'(LOCK_CLKS));

  // refresh interval timer
  logic [REFI_W-1:0] refiCnt;
  logic              refTick;
  assign refTick = stb.refRun && (refiCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         refiCnt <= REFI_W'(REFI_CYC - 1);
    else if (!stb.refRun || refTick)   refiCnt <= REFI_W'(REFI_CYC - 1);
    else                               refiCnt <= refiCnt - 1'b1;
  end

  // pending refresh counter
  logic [PEND_W-1:0] pendCnt;
  logic              refServe;
  assign refServe = stb.issue && (stb.cmd == CMD_REF) && stb.refRun;
  assign pendNz   = (pendCnt != '0);
  assign pendFull = (pendCnt == PEND_W'(MAX_PEND));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else begin
      case ({refTick, refServe})
        2'b10:   if (!pendFull) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // command encoding and output registers
  logic [2:0]        rcwNext;
  logic [1:0]        baNext;
  logic [ADDR_W-1:0] addrNext;

  always_comb begin
    rcwNext  = 3'b111;
    baNext   = 2'b00;
    addrNext = '0;
    if (stb.issue) begin
      case (stb.cmd)
        CMD_PALL: begin
          rcwNext      = 3'b010;
          addrNext[10] = 1'b1;
        end
        CMD_REF:  rcwNext = 3'b001;
        CMD_MRS: begin
          rcwNext       = 3'b000;
          addrNext[2:0] = burstLen;
          addrNext[3]   = burstInterleave;
          addrNext[6:4] = casLat;
          addrNext[8]   = stb.dllRst;
        end
        CMD_EMRS: begin
          rcwNext = 3'b000;
          baNext  = 2'b01;
        end
        default: rcwNext = 3'b111;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ddrCke  <= 1'b0;
      ddrCsN  <= 1'b1;
      ddrRasN <= 1'b1;
      ddrCasN <= 1'b1;
      ddrWeN  <= 1'b1;
      ddrBa   <= '0;
      ddrAddr <= '0;
    end else begin
      ddrCke  <= 1'b1;
      ddrCsN  <= 1'b0;
      {ddrRasN, ddrCasN, ddrWeN} <= rcwNext;
      ddrBa   <= baNext;
      ddrAddr <= addrNext;
    end
  end

  a_r10_pend_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (refTick && !refServe && pendFull) |=> pendFull);

  a_r9_serve_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    refServe |-> pendNz);

  a_r1_cke_before_command: assert property (@(posedge clk) disable iff (!rstN)
    !ddrCsN |-> ddrCke);

endmodule

// File: rtl/ddrseq_ctrl.sv
module ddrseq_ctrl
  import ddrseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refGrant,
  input  logic        gapDone,
  input  logic        lockDone,
  input  logic        pendNz,
  input  logic        pendFull,
  output seq_strobe_t stb,
  output logic        initDone,
  output logic        refReq,
  output logic        refUrgent
);

  typedef enum logic [3:0] {
    ST_PALL_A,
    ST_EMRS,
    ST_MRS_RST,
    ST_PALL_B,
    ST_REF_A,
    ST_REF_B,
    ST_MRS_RUN,
    ST_LOCK,
    ST_READY
  } state_e;

  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PALL_A;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    stb.issue  = 1'b0;
    stb.cmd    = CMD_NOP;
    stb.dllRst = 1'b0;
    stb.gap    = GAP_MRD;
    stb.refRun = 1'b0;
    case (state)
      ST_PALL_A: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_PALL; stb.gap = GAP_RP;
        stateNext = ST_EMRS;
      end
      ST_EMRS: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_EMRS; stb.gap = GAP_MRD;
        stateNext = ST_MRS_RST;
      end
      ST_MRS_RST: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_MRS; stb.dllRst = 1'b1; stb.gap = GAP_MRD;
        stateNext = ST_PALL_B;
      end
      ST_PALL_B: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_PALL; stb.gap = GAP_RP;
        stateNext = ST_REF_A;
      end
      ST_REF_A: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_REF; stb.gap = GAP_RFC;
        stateNext = ST_REF_B;
      end
      ST_REF_B: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_REF; stb.gap = GAP_RFC;
        stateNext = ST_MRS_RUN;
      end
      ST_MRS_RUN: if (gapDone) begin
        stb.issue = 1'b1; stb.cmd = CMD_MRS; stb.gap = GAP_MRD;
        stateNext = ST_LOCK;
      end
      ST_LOCK: if (gapDone && lockDone) stateNext = ST_READY;
      ST_READY: begin
        stb.refRun = 1'b1;
        if (gapDone && pendNz && refGrant) begin
          stb.issue = 1'b1; stb.cmd = CMD_REF; stb.gap = GAP_RFC;
        end
      end
      default: stateNext = ST_PALL_A;
    endcase
  end

  assign initDone  = (state == ST_READY);
  assign refReq    = initDone && pendNz;
  assign refUrgent = initDone && pendFull;

  a_r7_ready_after_lock: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> lockDone);

  a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rstN)
    stb.issue |=> !stb.issue);

endmodule

// File: rtl/ddr_init_refresh.sv
module ddr_init_refresh
  import ddrseq_pkg::*;
#(
  parameter int TCK_PS     = 5000,
  parameter int STARTUP_NS = 200000,
  parameter int TRP_NS     = 15,
  parameter int TRFC_NS    = 70,
  parameter int TMRD_CLKS  = 2,
  parameter int TREFI_NS   = 15600,
  parameter int LOCK_CLKS  = 200,
  parameter int MAX_PEND   = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        burstLen,
  input  logic              burstInterleave,
  input  logic [2:0]        casLat,
  input  logic              refGrant,
  output logic              ddrCke,
  output logic              ddrCsN,
  output logic              ddrRasN,
  output logic              ddrCasN,
  output logic              ddrWeN,
  output logic [1:0]        ddrBa,
  output logic [ADDR_W-1:0] ddrAddr,
  output logic              initDone,
  output logic              refReq,
  output logic              refUrgent
);

  seq_strobe_t stb;
  logic gapDone, lockDone, pendNz, pendFull;

  ddrseq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refGrant  (refGrant),
    .gapDone   (gapDone),
    .lockDone  (lockDone),
    .pendNz    (pendNz),
    .pendFull  (pendFull),
    .stb       (stb),
    .initDone  (initDone),
    .refReq    (refReq),
    .refUrgent (refUrgent)
  );

  ddrseq_datapath #(
    .TCK_PS     (TCK_PS),
    .STARTUP_NS (STARTUP_NS),
    .TRP_NS     (TRP_NS),
    .TRFC_NS    (TRFC_NS),
    .TMRD_CLKS  (TMRD_CLKS),
    .TREFI_NS   (TREFI_NS),
    .LOCK_CLKS  (LOCK_CLKS),
    .MAX_PEND   (MAX_PEND),
    .ADDR_W     (ADDR_W)
  ) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .stb             (stb),
    .burstLen        (burstLen),
    .burstInterleave (burstInterleave),
    .casLat          (casLat),
    .gapDone         (gapDone),
    .lockDone        (lockDone),
    .pendNz          (pendNz),
    .pendFull        (pendFull),
    .ddrCke          (ddrCke),
    .ddrCsN          (ddrCsN),
    .ddrRasN         (ddrRasN),
    .ddrCasN         (ddrCasN),
    .ddrWeN          (ddrWeN),
    .ddrBa           (ddrBa),
    .ddrAddr         (ddrAddr)
  );

  a_r11_urgent_implies_request: assert property (@(posedge clk) disable iff (!rstN)
    refUrgent |-> refReq);

endmodule

// File: tb/ddr_init_refresh_tb.sv
module ddr_init_refresh_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STARTUP    = 200;   // 1000 ns at 5 ns
  localparam int RP         = 3;
  localparam int RFC        = 14;
  localparam int MRD        = 2;
  localparam int LOCK       = 200;
  localparam int TREFI      = 400;   // 2000 ns at 5 ns
  localparam int MAXP       = 8;

  // kinds: 1 precharge-all, 2 auto-refresh, 3 mode write (BA selects register)
  localparam int EXP_KIND [7] = '{1, 3, 3, 1, 2, 2, 3};
  localparam int EXP_GAP  [7] = '{0, RP, MRD, MRD, RP, RFC, RFC};
  localparam int EXP_ADDR [7] = '{'h400, 'h000, 'h16B, 'h400, 'h000, 'h000, 'h06B};
  localparam int EXP_BA   [7] = '{0, 1, 0, 0, 0, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] burstLen = 3'b011;
  logic burstInterleave = 1'b1;
  logic [2:0] casLat = 3'b110;
  logic refGrant = 1'b0;
  logic ddrCke, ddrCsN, ddrRasN, ddrCasN, ddrWeN;
  logic [1:0] ddrBa;
  logic [11:0] ddrAddr;
  logic initDone, refReq, refUrgent;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_init_refresh #(
    .TCK_PS(5000), .STARTUP_NS(1000), .TREFI_NS(2000)
  ) u_dut (
    .clk(clk), .rstN(rstN), .burstLen(burstLen), .burstInterleave(burstInterleave),
    .casLat(casLat), .refGrant(refGrant), .ddrCke(ddrCke), .ddrCsN(ddrCsN),
    .ddrRasN(ddrRasN), .ddrCasN(ddrCasN), .ddrWeN(ddrWeN), .ddrBa(ddrBa),
    .ddrAddr(ddrAddr), .initDone(initDone), .refReq(refReq), .refUrgent(refUrgent)
  );

  // monitor: cycle count and command log, sampled at the falling edge
  int cyc = 0;
  int relCyc = -1, readyCyc = -1, reqCyc = -1, urgCyc = -1, grantCyc = -1;
  int logN = 0;
  int logK [64];
  int logC [64];
  int logA [64];
  int logB [64];
  logic grantSeen = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rstN && relCyc < 0) relCyc = cyc;
    if (initDone && readyCyc < 0) readyCyc = cyc;
    if (refReq && reqCyc < 0) reqCyc = cyc;
    if (refUrgent && urgCyc < 0) urgCyc = cyc;
    if (refGrant && !grantSeen) grantCyc = cyc;
    grantSeen = refGrant;
    if (rstN && !ddrCsN && !(ddrRasN && ddrCasN && ddrWeN) && logN < 64) begin
      if (!ddrRasN && ddrCasN && !ddrWeN)       logK[logN] = 1;
      else if (!ddrRasN && !ddrCasN && ddrWeN)  logK[logN] = 2;
      else if (!ddrRasN && !ddrCasN && !ddrWeN) logK[logN] = 3;
      else                                      logK[logN] = 4;
      logC[logN] = cyc;
      logA[logN] = int'(ddrAddr);
      logB[logN] = int'(ddrBa);
      logN = logN + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog actual=timeout expected=complete");
    finishRun();
  end

  initial begin
    int refBase;
    int lim;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 cke in reset", int'(ddrCke), 0);
    chk("R1 cs in reset", int'(ddrCsN), 1);
    chk("R1 initDone in reset", int'(initDone), 0);
    chk("R1 refReq/refUrgent in reset", int'(refReq | refUrgent), 0);
    @(posedge clk);
    rstN <= 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cke after reset", int'(ddrCke), 1);
    chk("R1 nop after reset", int'({ddrCsN, ddrRasN, ddrCasN, ddrWeN}), 7);

    while (!initDone) @(posedge clk);
    repeat (2) @(negedge clk);

    chk("R3 init command count", logN, 7);
    for (int i = 0; i < 7; i++) begin
      chk($sformatf("R3 kind step %0d", i), logK[i], EXP_KIND[i]);
      chk($sformatf("R5 address step %0d (R4 for extended)", i), logA[i], EXP_ADDR[i]);
      chk($sformatf("R4 bank step %0d", i), logB[i], EXP_BA[i]);
      if (i == 0) chkRange("R2 startup delay", logC[0] - relCyc, STARTUP, STARTUP + 2);
      else        chk($sformatf("R6 gap step %0d", i), logC[i] - logC[i-1], EXP_GAP[i]);
    end
    chkRange("R7 lock wait after DLL reset", readyCyc - logC[2], LOCK, LOCK + 3);

    lim = 0;
    while (urgCyc < 0 && lim < 5000) begin @(posedge clk); lim++; end
    @(negedge clk);
    chk("R8 first request delay", reqCyc - readyCyc, TREFI);
    chk("R11 urgent delay", urgCyc - readyCyc, MAXP * TREFI);
    chk("R9 no command without grant", logN, 7);

    repeat (2 * TREFI) @(posedge clk);
    refBase = logN;
    refGrant <= 1'b1;
    lim = 0;
    @(posedge clk);
    while (refReq && lim < 1000) begin @(posedge clk); lim++; end
    repeat (RFC + 2) @(posedge clk);
    refGrant <= 1'b0;
    @(negedge clk);
    chk("R10 refreshes served after saturation", logN - refBase, MAXP);
    chk("R9 refresh one cycle after grant", logC[refBase] - grantCyc, 1);
    for (int i = refBase + 1; i < logN; i++) begin
      chk("R6 refresh spacing tRFC", logC[i] - logC[i-1], RFC);
      chk("R9 served command is auto-refresh", logK[i], 2);
    end
    chk("R11 urgent cleared", int'(refUrgent), 0);
    chk("R10 request cleared", int'(refReq), 0);

    lim = 0;
    while (!refReq && lim < 2 * TREFI) begin @(posedge clk); lim++; end
    refBase = logN;
    refGrant <= 1'b1;
    @(posedge clk);
    refGrant <= 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 single grant single refresh", logN - refBase, 1);
    chk("R9 pending consumed", int'(refReq), 0);

    finishRun();
  end

endmodule